// File: doc/BRIEF.md
# Precise Exception Control Unit

This block sequences traps for a five-stage in-order pipeline. Decode reports an unknown opcode and execute reports an arithmetic overflow, and each report comes with the program counter of its instruction. The block picks the oldest of the reports. It records a one-bit cause and the saved return address, which is the faulting address plus four. In the same cycle it asserts flush strobes for the faulting stage and every younger stage, and it gives fetch a handler address.

The flush strobes zero the control bits of the stages they cover. A flushed execute stage therefore never writes its destination register. Instructions older than the faulting one are not flushed and complete normally. A mode pin selects between two vector schemes. In the first, every cause enters one fixed handler. In the second, each cause has its own entry point, and the entry points are spaced evenly.

A two-state controller handles the trap sequence. In state `ST_RUN`, reports are accepted. A taken trap moves the controller to state `ST_SETTLE` for one cycle, and reports are ignored in that cycle. The controller then returns to `ST_RUN` on its own. The transitions are: RUN→SETTLE when a valid report arrives, RUN→RUN when there is none, and SETTLE→RUN always.

Top module: `exc_unit`

## Requirements
- R1: While reset is held, and in the first cycle after reset, `cause_bit` is 0, `epc` is 0, and `take_trap` and all flush strobes are low.
- R2: An unknown opcode in decode (`id_valid`=1, `id_undef`=1) with no overflow in execute raises `take_trap`, `flush_fetch` and `flush_decode`, and leaves `flush_execute` low. On the next edge, `cause_bit` becomes 0 and `epc` becomes `id_pc`+4.
- R3: An overflow in execute (`ex_valid`=1, `ex_ovf`=1) raises `take_trap`, `flush_fetch`, `flush_decode` and `flush_execute`, so its register write is dropped. On the next edge, `cause_bit` becomes 1 and `epc` becomes `ex_pc`+4.
- R4: When both reports arrive in the same cycle, the execute overflow is taken, because that instruction is older: cause 1 and `ex_pc`+4.
- R5: With `vec_mode`=0, `redirect_pc` is 0x80000180 for every cause.
- R6: With `vec_mode`=1, `redirect_pc` is 0xC0000000 plus 0x20 times the cause, which gives 0xC0000000 for an unknown opcode and 0xC0000020 for an overflow.
- R7: `cause_bit` and `epc` change only on an edge where `take_trap` is high, and hold their values otherwise.
- R8: In the cycle right after a taken trap, any report is ignored: `take_trap` and the flush strobes stay low, and `cause_bit` and `epc` hold.
- R9: A report whose valid bit is low (a bubble) is ignored.
- R10: The saved address wraps modulo 2^32: a fault at 0xFFFFFFFC saves 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_mode | input | 1 | 0 selects the single fixed handler, 1 selects one entry point per cause |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_undef | input | 1 | Decode found an unknown opcode |
| id_pc | input | 32 | Address of the decode instruction |
| ex_valid | input | 1 | Execute stage holds a real instruction |
| ex_ovf | input | 1 | Execute produced an arithmetic overflow |
| ex_pc | input | 32 | Address of the execute instruction |
| take_trap | output | 1 | A trap is taken this cycle; fetch must load `redirect_pc` |
| flush_fetch | output | 1 | Zero the fetch/decode pipeline register |
| flush_decode | output | 1 | Zero the control bits entering execute |
| flush_execute | output | 1 | Zero the control bits entering memory, which drops the register write |
| redirect_pc | output | 32 | Handler address for fetch |
| cause_bit | output | 1 | Recorded cause: 0 unknown opcode, 1 overflow |
| epc | output | 32 | Recorded faulting address plus 4 |

## Verification
The bench drives both reports in the same cycle. A design that ranked decode first would record cause 0 and the younger address, and it would let an overflowing result reach the register file. The bench checks that a decode fault leaves `flush_execute` low. A design that flushed too much would kill an older instruction. The bench also sends reports in the cycle after a trap and reports whose valid bit is low. A design that took either would overwrite the saved address with a stale or phantom fault. A fault at the top of the address space checks that the saved address wraps to zero rather than being clipped.

// File: rtl/exc_pkg.sv
package exc_pkg;
    typedef enum logic [0:0] {
        ST_RUN    = 1'b0,
        ST_SETTLE = 1'b1
    } exc_state_e;

    localparam int CAUSE_UNDEF = 0;
    localparam int CAUSE_OVF   = 1;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
    parameter int XLEN = 32,
    parameter int CW   = 1
) (
    input  logic            armed,
    input  logic            id_valid,
    input  logic            id_undef,
    input  logic [XLEN-1:0] id_pc,
    input  logic            ex_valid,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc,
    output logic            hit,
    output logic            hit_ex,
    output logic [CW-1:0]   cause,
    output logic [XLEN-1:0] ret_pc
);
    import exc_pkg::*;

    logic dec_fault;
    logic exe_fault;

    assign dec_fault = armed && id_valid && id_undef;
    assign exe_fault = armed && ex_valid && ex_ovf;

    // The execute instruction is older, so its fault ranks first.
    always_comb begin
        hit    = dec_fault || exe_fault;
        hit_ex = exe_fault;
        if (exe_fault) begin
            cause  = CW'(CAUSE_OVF);
            ret_pc = ex_pc + XLEN'(4);
        end else begin
            cause  = CW'(CAUSE_UNDEF);
            ret_pc = id_pc + XLEN'(4);
        end
    end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
    parameter int              XLEN       = 32,
    parameter int              NUM_CAUSES = 2,
    parameter int              CW         = 1,
    parameter logic [XLEN-1:0] FIXED_VEC  = 32'h8000_0180,
    parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
    parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0020
) (
    input  logic            vec_mode,
    input  logic [CW-1:0]   cause,
    output logic [XLEN-1:0] handler
);
    logic [XLEN-1:0] entry [NUM_CAUSES];

    for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_entry
        assign entry[c] = VEC_BASE + XLEN'(c) * VEC_STRIDE;
    end

    always_comb begin
        if (vec_mode) handler = entry[cause];
        else          handler = FIXED_VEC;
    end
endmodule

// File: rtl/exc_fsm.sv
module exc_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic armed,
    output logic take
);
    import exc_pkg::*;

    exc_state_e state_q;
    exc_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (hit) state_d = ST_SETTLE;
            ST_SETTLE: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        armed = 1'b0;
        take  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                armed = rst_n;
                take  = hit;
            end
            ST_SETTLE: begin
                armed = 1'b0;
                take  = 1'b0;
            end
            default: begin
                armed = 1'b0;
                take  = 1'b0;
            end
        endcase
    end

    // R8: no trap may be taken in the cycle after one was taken
    assert_no_back_to_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);
endmodule

// File: rtl/exc_unit.sv
module exc_unit #(
    parameter int              XLEN       = 32,
    parameter int              NUM_CAUSES = 2,
    parameter logic [XLEN-1:0] FIXED_VEC  = 32'h8000_0180,
    parameter logic [XLEN-1:0] VEC_BASE   = 32'hC000_0000,
    parameter logic [XLEN-1:0] VEC_STRIDE = 32'h0000_0020
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            vec_mode,
    input  logic            id_valid,
    input  logic            id_undef,
    input  logic [XLEN-1:0] id_pc,
    input  logic            ex_valid,
    input  logic            ex_ovf,
    input  logic [XLEN-1:0] ex_pc,
    output logic            take_trap,
    output logic            flush_fetch,
    output logic            flush_decode,
    output logic            flush_execute,
    output logic [XLEN-1:0] redirect_pc,
    output logic            cause_bit,
    output logic [XLEN-1:0] epc
);
    localparam int CW = (NUM_CAUSES > 1) ? $clog2(NUM_CAUSES) : 1;

    logic            armed;
    logic            hit;
    logic            hit_ex;
    logic [CW-1:0]   sel_cause;
    logic [XLEN-1:0] sel_ret;
    logic [CW-1:0]   cause_q;
    logic [XLEN-1:0] epc_q;

    exc_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .hit   (hit),
        .armed (armed),
        .take  (take_trap)
    );

    exc_arbiter #(.XLEN(XLEN), .CW(CW)) u_arb (
        .armed    (armed),
        .id_valid (id_valid),
        .id_undef (id_undef),
        .id_pc    (id_pc),
        .ex_valid (ex_valid),
        .ex_ovf   (ex_ovf),
        .ex_pc    (ex_pc),
        .hit      (hit),
        .hit_ex   (hit_ex),
        .cause    (sel_cause),
        .ret_pc   (sel_ret)
    );

    exc_vector #(
        .XLEN(XLEN), .NUM_CAUSES(NUM_CAUSES), .CW(CW),
        .FIXED_VEC(FIXED_VEC), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) u_vec (
        .vec_mode (vec_mode),
        .cause    (sel_cause),
        .handler  (redirect_pc)
    );

    // The faulting stage and every younger stage are cleared.
    assign flush_fetch   = take_trap;
    assign flush_decode  = take_trap;
    assign flush_execute = take_trap && hit_ex;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q <= '0;
            epc_q   <= '0;
        end else if (take_trap) begin
            cause_q <= sel_cause;
            epc_q   <= sel_ret;
        end
    end

    assign cause_bit = cause_q[0];
    assign epc       = epc_q;

    // R7: recorded state holds without a trap
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !take_trap |=> ($stable(cause_q) && $stable(epc_q)));
    // R3: an execute flush records the overflow cause
    assert_ovf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flush_execute |=> cause_bit);
    // R4: an overflow report always flushes execute
    assert_oldest_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && ex_valid && ex_ovf) |-> flush_execute);
    // R5: fixed mode always uses the single handler
    assert_fixed_vec_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && !vec_mode) |-> (redirect_pc == FIXED_VEC));
    // R6: vectored overflow entry
    assert_vec_ovf_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_trap && vec_mode && flush_execute) |-> (redirect_pc == VEC_BASE + VEC_STRIDE));
    // R9: bubbles never trap
    assert_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_valid && !ex_valid) |-> !take_trap);
endmodule

// File: tb/sim_exc_unit.sv
module sim_exc_unit;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [23:0] tag;
        logic        mode;
        logic        idv;
        logic        idu;
        logic [31:0] idpc;
        logic        exv;
        logic        exo;
        logic [31:0] expc;
        logic        e_take;
        logic        e_fex;
        logic [31:0] e_handler;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TABLE [NV] = '{
        '{"R2 ", 1'b0, 1'b1, 1'b1, 32'h0000_0100, 1'b0, 1'b0, 32'h0,          1'b1, 1'b0, 32'h8000_0180}, // R5 fixed, undef
        '{"R6 ", 1'b1, 1'b1, 1'b1, 32'h0000_0200, 1'b0, 1'b0, 32'h0,          1'b1, 1'b0, 32'hC000_0000},
        '{"R3 ", 1'b0, 1'b0, 1'b0, 32'h0,         1'b1, 1'b1, 32'h0000_0300, 1'b1, 1'b1, 32'h8000_0180}, // R5 fixed, ovf
        '{"R6 ", 1'b1, 1'b0, 1'b0, 32'h0,         1'b1, 1'b1, 32'h0000_0400, 1'b1, 1'b1, 32'hC000_0020},
        '{"R4 ", 1'b1, 1'b1, 1'b1, 32'h0000_0504, 1'b1, 1'b1, 32'h0000_0500, 1'b1, 1'b1, 32'hC000_0020},
        '{"R9 ", 1'b1, 1'b0, 1'b1, 32'h0000_0600, 1'b0, 1'b0, 32'h0,          1'b0, 1'b0, 32'h0},
        '{"R9 ", 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b1, 32'h0000_0700, 1'b0, 1'b0, 32'h0},
        '{"R10", 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFC, 1'b0, 1'b0, 32'h0,          1'b1, 1'b0, 32'hC000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vec_mode = 1'b0;
    logic        id_valid = 1'b0;
    logic        id_undef = 1'b0;
    logic [31:0] id_pc = '0;
    logic        ex_valid = 1'b0;
    logic        ex_ovf = 1'b0;
    logic [31:0] ex_pc = '0;
    logic        take_trap, flush_fetch, flush_decode, flush_execute, cause_bit;
    logic [31:0] redirect_pc, epc;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;
    logic        m_cause = 1'b0;
    logic [31:0] m_epc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_unit u0 (
        .clk(clk), .rst_n(rst_n), .vec_mode(vec_mode),
        .id_valid(id_valid), .id_undef(id_undef), .id_pc(id_pc),
        .ex_valid(ex_valid), .ex_ovf(ex_ovf), .ex_pc(ex_pc),
        .take_trap(take_trap), .flush_fetch(flush_fetch), .flush_decode(flush_decode),
        .flush_execute(flush_execute), .redirect_pc(redirect_pc),
        .cause_bit(cause_bit), .epc(epc)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle();
        id_valid = 1'b0; id_undef = 1'b0; id_pc = '0;
        ex_valid = 1'b0; ex_ovf = 1'b0; ex_pc = '0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got running expected finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        check("R1", "take in reset", 32'(take_trap), 32'd0);
        check("R1", "cause in reset", 32'(cause_bit), 32'd0);
        check("R1", "epc in reset", epc, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "flush after reset", 32'({flush_fetch, flush_decode, flush_execute}), 32'd0);

        for (int i = 0; i < NV; i++) begin
            string t;
            t = $sformatf("%s", TABLE[i].tag);
            vec_mode = TABLE[i].mode;
            id_valid = TABLE[i].idv; id_undef = TABLE[i].idu; id_pc = TABLE[i].idpc;
            ex_valid = TABLE[i].exv; ex_ovf = TABLE[i].exo; ex_pc = TABLE[i].expc;
            #1;
            check(t, "take", 32'(take_trap), 32'(TABLE[i].e_take));
            check(t, "flush_fetch", 32'(flush_fetch), 32'(TABLE[i].e_take));
            check(t, "flush_decode", 32'(flush_decode), 32'(TABLE[i].e_take));
            check(t, "flush_execute", 32'(flush_execute), 32'(TABLE[i].e_fex));
            if (TABLE[i].e_take) begin
                check(t, "redirect", redirect_pc, TABLE[i].e_handler);
                if (TABLE[i].exv && TABLE[i].exo) begin
                    m_cause = 1'b1; m_epc = TABLE[i].expc + 32'd4;
                end else begin
                    m_cause = 1'b0; m_epc = TABLE[i].idpc + 32'd4;
                end
            end
            @(negedge clk);
            idle();
            check(t, "cause", 32'(cause_bit), 32'(m_cause));
            check(t, "epc", epc, m_epc);
            @(negedge clk);
        end

        // R8: report in the cycle after a trap is ignored
        vec_mode = 1'b1;
        id_valid = 1'b1; id_undef = 1'b1; id_pc = 32'h0000_0700;
        #1;
        check("R8", "first take", 32'(take_trap), 32'd1);
        @(negedge clk);
        idle();
        ex_valid = 1'b1; ex_ovf = 1'b1; ex_pc = 32'h0000_0800;
        #1;
        check("R8", "take in settle", 32'(take_trap), 32'd0);
        check("R8", "flush_execute in settle", 32'(flush_execute), 32'd0);
        @(negedge clk);
        idle();
        check("R8", "cause after settle", 32'(cause_bit), 32'd0);
        check("R8", "epc after settle", epc, 32'h0000_0704);

        // R7: hold across idle cycles
        repeat (4) @(negedge clk);
        check("R7", "cause hold", 32'(cause_bit), 32'd0);
        check("R7", "epc hold", epc, 32'h0000_0704);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule